// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves a programmed number of bytes between system memory and a card data port. Software lays out a linked list of descriptors in memory, gives the block the address of the first one, the byte count, the direction and the enable, and pulses `start`. The engine then walks the list on its own.

For each descriptor the engine fetches four words: status, buffer size, buffer address and next-descriptor address. It then moves the smaller of the descriptor's size and the bytes still owed. It writes the status word back with the ownership bit cleared, and either stops or follows the next pointer. In the memory-to-card direction each word is read from memory and offered on the transmit stream. In the card-to-memory direction each word is taken from the receive stream and written to memory.

When the engine stops it raises sticky completion flags, and these stay set until `clrFlags` is pulsed. The memory side is a single-word request/acknowledge master. The card side uses two valid/ready word streams and a data-ready level.

Top module: `desc_chain_dma`

## Requirements
- R1: A descriptor is four consecutive 32-bit words at its address: status at +0, size at +4, buffer address at +8 and next-descriptor address at +12. The first descriptor is at `descBase`, and each later one is at the previous descriptor's next word.
- R2: A size word of 0, or one above MAX_DESC_BYTES, is treated as MAX_DESC_BYTES.
- R3: Each descriptor moves min(size, bytes remaining) bytes as ceil(bytes/4) words, starting at the buffer address with its two low bits forced to 0 and rising by 4 per word.
- R4: After its data has moved, each descriptor gets its status word written back to the descriptor address with bit 31 (owned) cleared. Every other status bit is kept (bit 30 error, bit 4 chained, bit 3 first, bit 2 last, bit 1 no-interrupt).
- R5: The engine stops after a descriptor whose status bit 2 is set, or when the bytes remaining reach 0. Otherwise it fetches the descriptor at the next pointer. A descriptor past the stopping point is neither read nor written.
- R6: `start` is ignored, with no memory access and no change to `bytesLeft` or the flags, if any of these holds: `byteCount` is 0, `blockSize` is 0, `dmaEnable` is low, or `isWrite` is 0 while `cardDataReady` is low.
- R7: On stopping, `dataDone`, `listDone` and `dmaSummary` are set, together with `txDone` for a memory-to-card run or `rxDone` for a card-to-memory run.
- R8: `bytesLeft` loads `byteCount` at start and drops by each descriptor's moved bytes, saturating at 0. `dataDone` is set when it reaches 0.
- R9: After reset the engine is idle with all flags 0 and no request. The flags stay set until `clrFlags` is pulsed, and a set in the same cycle as a clear wins.
- R10: A memory request holds its address, write enable and data until `memAck`. A transmit word holds its data until `cardTxReady`. A receive word is taken only when both `cardRxValid` and `cardRxReady` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Pulse to begin a run |
| dmaEnable | input | 1 | Engine enable |
| isWrite | input | 1 | 1: memory to card, 0: card to memory |
| byteCount | input | CNT_W | Bytes to move |
| blockSize | input | CNT_W | Card block size (only zero is checked) |
| descBase | input | 32 | Address of first descriptor |
| clrFlags | input | 1 | Clear all completion flags |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory acknowledge, read data valid |
| memRdata | input | 32 | Memory read data |
| cardDataReady | input | 1 | Card has read data available |
| cardTxValid | output | 1 | Transmit word valid |
| cardTxData | output | 32 | Transmit word |
| cardTxReady | input | 1 | Card accepts transmit word |
| cardRxValid | input | 1 | Receive word valid |
| cardRxData | input | 32 | Receive word |
| cardRxReady | output | 1 | Engine accepts receive word |
| busy | output | 1 | Run in progress |
| bytesLeft | output | CNT_W | Bytes still owed |
| dataDone | output | 1 | Data-complete flag |
| listDone | output | 1 | List-finished flag |
| dmaSummary | output | 1 | Engine summary flag |
| txDone | output | 1 | Transmit-direction completion |
| rxDone | output | 1 | Receive-direction completion |

## Verification
The bench builds descriptor lists out of address order and ends them three ways. A design that walked addresses in sequence instead of following next pointers would send the wrong words to the card. One ending is a final descriptor cut short by the remaining count, and a design that ignored the minimum would overrun. Another is a count that runs out before any last bit, where a design that kept going would fetch the next descriptor and clear its owned bit. Size 0 and oversize descriptors are used with an unaligned buffer address. A missing clamp or address mask would move the wrong number of words or write beside the buffer. Each refused-start condition is also tried: an engine that started anyway would touch memory, reload `bytesLeft` or raise flags.

// File: rtl/desc_chain_dma_pkg.sv
package desc_chain_dma_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 2;

  typedef enum logic [1:0] {SEL_DESC, SEL_BUF, SEL_STAT} memSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadStart;
    logic    captureWord;
    logic    planMove;
    logic    captureData;
    logic    wordDone;
    logic    commitDesc;
    logic    followNext;
    logic    finish;
    memSel_t memSel;
  } pathCtl_t;
endpackage

// File: rtl/desc_chain_dma_path.sv
module desc_chain_dma_path
  import desc_chain_dma_pkg::*;
#(
  parameter int MAX_DESC_BYTES = 8192,
  parameter int CNT_W          = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic              isWrite,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [WORD_W-1:0] descBase,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] cardRxData,
  input  logic              clrFlags,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] cardTxData,
  output logic [CNT_W-1:0]  bytesLeft,
  output logic              dirWrite,
  output logic              fetchLastWord,
  output logic              wordsOne,
  output logic              descIsLast,
  output logic              remainZero,
  output logic              dataDone,
  output logic              listDone,
  output logic              dmaSummary,
  output logic              txDone,
  output logic              rxDone
);
  localparam int SIZE_W = $clog2(MAX_DESC_BYTES) + 1;

  logic [WORD_W-1:0] curDesc, descStatus, descSize, descBuf, descNext;
  logic [WORD_W-1:0] bufPtr, holdWord;
  logic [1:0]        fetchIdx;
  logic [SIZE_W-1:0] wordsLeft, moveBytes;
  logic [CNT_W-1:0]  remain;

  logic [SIZE_W-1:0] clampSize, moveLen;
  logic [SIZE_W:0]   roundUp;
  logic [CNT_W-1:0]  remainNext;

  // size clamp and per-descriptor byte budget
  always_comb begin
    if (descSize == '0 || descSize > WORD_W'(MAX_DESC_BYTES))
      clampSize = SIZE_W'(MAX_DESC_BYTES);
    else
      clampSize = descSize[SIZE_W-1:0];
    moveLen = (remain < CNT_W'(clampSize)) ? remain[SIZE_W-1:0] : clampSize;
    roundUp = {1'b0, moveLen} + (SIZE_W+1)'(3);
    remainNext = (remain > CNT_W'(moveBytes)) ? remain - CNT_W'(moveBytes) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDesc    <= '0;
      descStatus <= '0;
      descSize   <= '0;
      descBuf    <= '0;
      descNext   <= '0;
      fetchIdx   <= '0;
      remain     <= '0;
      dirWrite   <= 1'b0;
    end else begin
      if (ctl.loadStart) begin
        curDesc  <= descBase;
        remain   <= byteCount;
        dirWrite <= isWrite;
        fetchIdx <= '0;
      end
      if (ctl.captureWord) begin
        case (fetchIdx)
          2'd0:    descStatus <= memRdata;
          2'd1:    descSize   <= memRdata;
          2'd2:    descBuf    <= memRdata;
          default: descNext   <= memRdata;
        endcase
        fetchIdx <= fetchIdx + 2'd1;
      end
      if (ctl.commitDesc) remain <= remainNext;
      if (ctl.followNext) begin
        curDesc  <= descNext;
        fetchIdx <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufPtr    <= '0;
      wordsLeft <= '0;
      moveBytes <= '0;
      holdWord  <= '0;
    end else begin
      if (ctl.planMove) begin
        bufPtr    <= {descBuf[WORD_W-1:2], 2'b00};
        wordsLeft <= SIZE_W'(roundUp[SIZE_W:2]);
        moveBytes <= moveLen;
      end
      if (ctl.captureData) holdWord <= dirWrite ? memRdata : cardRxData;
      if (ctl.wordDone) begin
        bufPtr    <= bufPtr + WORD_W'(4);
        wordsLeft <= wordsLeft - SIZE_W'(1);
      end
    end
  end

  // sticky flags: clear first, a set in the same cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataDone   <= 1'b0;
      listDone   <= 1'b0;
      dmaSummary <= 1'b0;
      txDone     <= 1'b0;
      rxDone     <= 1'b0;
    end else begin
      if (clrFlags) begin
        dataDone   <= 1'b0;
        listDone   <= 1'b0;
        dmaSummary <= 1'b0;
        txDone     <= 1'b0;
        rxDone     <= 1'b0;
      end
      if (ctl.commitDesc && remainNext == '0) dataDone <= 1'b1;
      if (ctl.finish) begin
        dataDone   <= 1'b1;
        listDone   <= 1'b1;
        dmaSummary <= 1'b1;
        if (dirWrite) txDone <= 1'b1;
        else          rxDone <= 1'b1;
      end
    end
  end

  always_comb begin
    case (ctl.memSel)
      SEL_DESC: memAddr = curDesc + WORD_W'({fetchIdx, 2'b00});
      SEL_BUF:  memAddr = bufPtr;
      default:  memAddr = curDesc;
    endcase
    if (ctl.memSel == SEL_STAT) begin
      memWdata          = descStatus;
      memWdata[OWN_BIT] = 1'b0;
    end else begin
      memWdata = holdWord;
    end
  end

  assign cardTxData    = holdWord;
  assign bytesLeft     = remain;
  assign fetchLastWord = (fetchIdx == 2'd3);
  assign wordsOne      = (wordsLeft == SIZE_W'(1));
  assign descIsLast    = descStatus[LAST_BIT];
  assign remainZero    = (remain == '0);
endmodule

// File: rtl/desc_chain_dma_ctrl.sv
module desc_chain_dma_ctrl
  import desc_chain_dma_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dmaEnable,
  input  logic             isWrite,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [CNT_W-1:0] blockSize,
  input  logic             cardDataReady,
  input  logic             memAck,
  input  logic             cardTxReady,
  input  logic             cardRxValid,
  input  logic             dirWrite,
  input  logic             fetchLastWord,
  input  logic             wordsOne,
  input  logic             descIsLast,
  input  logic             remainZero,
  output pathCtl_t         ctl,
  output logic             memReq,
  output logic             memWe,
  output logic             cardTxValid,
  output logic             cardRxReady,
  output logic             busy
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_PLAN, S_MEMRD, S_CARDTX,
    S_CARDRX, S_MEMWR, S_WBACK, S_STEP
  } state_t;

  state_t state, stateNext;
  logic   goOk;

  assign goOk = start && dmaEnable && (byteCount != '0) && (blockSize != '0)
                && (isWrite || cardDataReady);

  always_comb begin
    ctl         = '0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    cardTxValid = 1'b0;
    cardRxReady = 1'b0;
    stateNext   = state;
    case (state)
      S_IDLE: if (goOk) begin
        ctl.loadStart = 1'b1;
        stateNext     = S_FETCH;
      end
      S_FETCH: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_DESC;
        if (memAck) begin
          ctl.captureWord = 1'b1;
          if (fetchLastWord) stateNext = S_PLAN;
        end
      end
      S_PLAN: begin
        ctl.planMove = 1'b1;
        stateNext    = dirWrite ? S_MEMRD : S_CARDRX;
      end
      S_MEMRD: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_BUF;
        if (memAck) begin
          ctl.captureData = 1'b1;
          stateNext       = S_CARDTX;
        end
      end
      S_CARDTX: begin
        cardTxValid = 1'b1;
        if (cardTxReady) begin
          ctl.wordDone = 1'b1;
          stateNext    = wordsOne ? S_WBACK : S_MEMRD;
        end
      end
      S_CARDRX: begin
        cardRxReady = 1'b1;
        if (cardRxValid) begin
          ctl.captureData = 1'b1;
          stateNext       = S_MEMWR;
        end
      end
      S_MEMWR: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.memSel = SEL_BUF;
        if (memAck) begin
          ctl.wordDone = 1'b1;
          stateNext    = wordsOne ? S_WBACK : S_CARDRX;
        end
      end
      S_WBACK: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.memSel = SEL_STAT;
        if (memAck) begin
          ctl.commitDesc = 1'b1;
          stateNext      = S_STEP;
        end
      end
      S_STEP: begin
        if (descIsLast || remainZero) begin
          ctl.finish = 1'b1;
          stateNext  = S_IDLE;
        end else begin
          ctl.followNext = 1'b1;
          stateNext      = S_FETCH;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import desc_chain_dma_pkg::*;
#(
  parameter int MAX_DESC_BYTES = 8192,
  parameter int CNT_W          = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dmaEnable,
  input  logic              isWrite,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [CNT_W-1:0]  blockSize,
  input  logic [31:0]       descBase,
  input  logic              clrFlags,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  input  logic              cardDataReady,
  output logic              cardTxValid,
  output logic [31:0]       cardTxData,
  input  logic              cardTxReady,
  input  logic              cardRxValid,
  input  logic [31:0]       cardRxData,
  output logic              cardRxReady,
  output logic              busy,
  output logic [CNT_W-1:0]  bytesLeft,
  output logic              dataDone,
  output logic              listDone,
  output logic              dmaSummary,
  output logic              txDone,
  output logic              rxDone
);
  pathCtl_t ctl;
  logic dirWrite, fetchLastWord, wordsOne, descIsLast, remainZero;

  desc_chain_dma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dmaEnable(dmaEnable),
    .isWrite(isWrite), .byteCount(byteCount), .blockSize(blockSize),
    .cardDataReady(cardDataReady), .memAck(memAck), .cardTxReady(cardTxReady),
    .cardRxValid(cardRxValid), .dirWrite(dirWrite), .fetchLastWord(fetchLastWord),
    .wordsOne(wordsOne), .descIsLast(descIsLast), .remainZero(remainZero),
    .ctl(ctl), .memReq(memReq), .memWe(memWe), .cardTxValid(cardTxValid),
    .cardRxReady(cardRxReady), .busy(busy)
  );

  desc_chain_dma_path #(.MAX_DESC_BYTES(MAX_DESC_BYTES), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isWrite(isWrite), .byteCount(byteCount),
    .descBase(descBase), .memRdata(memRdata), .cardRxData(cardRxData),
    .clrFlags(clrFlags), .memAddr(memAddr), .memWdata(memWdata),
    .cardTxData(cardTxData), .bytesLeft(bytesLeft), .dirWrite(dirWrite),
    .fetchLastWord(fetchLastWord), .wordsOne(wordsOne), .descIsLast(descIsLast),
    .remainZero(remainZero), .dataDone(dataDone), .listDone(listDone),
    .dmaSummary(dmaSummary), .txDone(txDone), .rxDone(rxDone)
  );
endmodule

// File: rtl/desc_chain_dma_chk.sv
module desc_chain_dma_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             memWe,
  input logic [31:0]      memAddr,
  input logic [31:0]      memWdata,
  input logic             memAck,
  input logic             cardTxValid,
  input logic [31:0]      cardTxData,
  input logic             cardTxReady,
  input logic             cardRxReady,
  input logic             busy,
  input logic [CNT_W-1:0] bytesLeft,
  input logic             dmaSummary,
  input logic             txDone,
  input logic             rxDone
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardTxValid && !cardTxReady |=> cardTxValid && $stable(cardTxData));

  // R10
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cardTxValid && cardRxReady));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !cardTxValid && !cardRxReady);

  // R7
  finish_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> dmaSummary && (txDone || rxDone));

  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> bytesLeft <= $past(bytesLeft));
endmodule

bind desc_chain_dma desc_chain_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memAck(memAck), .cardTxValid(cardTxValid),
  .cardTxData(cardTxData), .cardTxReady(cardTxReady), .cardRxReady(cardRxReady),
  .busy(busy), .bytesLeft(bytesLeft), .dmaSummary(dmaSummary),
  .txDone(txDone), .rxDone(rxDone)
);

// File: tb/desc_chain_dma_bench.sv
module desc_chain_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 64;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, dmaEnable = 1'b1, isWrite = 1'b1, clrFlags = 1'b0;
  logic [CW-1:0] byteCount = '0, blockSize = 32'd512;
  logic [31:0] descBase = '0;
  logic memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic cardDataReady = 1'b1, cardTxValid, cardTxReady = 1'b1;
  logic cardRxValid = 1'b0, cardRxReady;
  logic [31:0] cardTxData, cardRxData;
  logic busy, dataDone, listDone, dmaSummary, txDone, rxDone;
  logic [CW-1:0] bytesLeft;

  desc_chain_dma #(.MAX_DESC_BYTES(MAXB), .CNT_W(CW)) u_desc_chain_dma (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [256];
  logic [31:0] txExp [$];
  int checks = 0, errors = 0, cyc = 0, rxIdx = 0, memReqSeen = 0, txSeen = 0;
  bit finished = 0;

  assign cardRxData = 32'hC0DE_0000 + rxIdx;

  // memory model: accept one request, acknowledge next cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memReq) memReqSeen <= memReqSeen + 1;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) mem[memAddr[9:2]] <= memWdata;
      else       memRdata <= mem[memAddr[9:2]];
    end else begin
      memAck <= 1'b0;
    end
    if (cardRxValid && cardRxReady) rxIdx <= rxIdx + 1;
  end

  always @(negedge clk) begin
    cardTxReady <= (cyc % 3) != 0;
    cardRxValid <= (cyc % 4) != 1;
  end

  // scoreboard monitor on transmit stream
  always @(posedge clk) begin
    if (rstN && cardTxValid && cardTxReady) begin
      txSeen <= txSeen + 1;
      checks++;
      if (txExp.size() == 0) begin
        errors++;
        $display("FAIL R1/R3 unexpected tx word act=%h exp=none", cardTxData);
      end else begin
        logic [31:0] e;
        e = txExp.pop_front();
        if (cardTxData !== e) begin
          errors++;
          $display("FAIL R1/R3 tx word act=%h exp=%h", cardTxData, e);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic putDesc(input int a, input logic [31:0] st, sz, buf_, nxt);
    mem[a>>2] = st; mem[(a>>2)+1] = sz; mem[(a>>2)+2] = buf_; mem[(a>>2)+3] = nxt;
  endtask

  task automatic fillBuf(input int a, input int n, input logic [31:0] seed);
    for (int k = 0; k < n; k++) mem[(a>>2)+k] = seed + k;
  endtask

  // driver: expected transmit words come from the bench's own memory image
  task automatic expectTx(input int a, input int n);
    for (int k = 0; k < n; k++) txExp.push_back(mem[(a>>2)+k]);
  endtask

  task automatic runDma(input bit w, input int cnt, input int base);
    @(negedge clk);
    isWrite = w; byteCount = cnt; descBase = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearFlags();
    @(negedge clk); clrFlags = 1'b1;
    @(negedge clk); clrFlags = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=busy exp=idle");
    finishRun();
  end

  initial begin
    int seenBefore;
    int txBefore;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A5A_0000 + i;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !memReq && !cardTxValid && !cardRxReady, "R9 reset idle", {28'd0, busy, memReq, cardTxValid, cardRxReady}, 0);
    check({dataDone, listDone, dmaSummary, txDone, rxDone} == 0, "R9 reset flags",
          {27'd0, dataDone, listDone, dmaSummary, txDone, rxDone}, 0);
    rstN = 1'b1;

    // single last descriptor, memory to card
    putDesc(32'h000, 32'h8000_000C, 16, 32'h100, 0);
    fillBuf(32'h100, 4, 32'hA000_0000);
    expectTx(32'h100, 4);
    runDma(1, 16, 32'h000);
    check(txExp.size() == 0, "R3 single desc words all sent", txExp.size(), 0);
    check(mem[0] == 32'h0000_000C, "R4 status written back", mem[0], 32'h0000_000C);
    check(bytesLeft == 0 && dataDone, "R8 count reaches zero", bytesLeft, 0);
    check({listDone, dmaSummary, txDone, rxDone} == 4'b1110, "R7 tx completion flags",
          {listDone, dmaSummary, txDone, rxDone}, 4'b1110);
    @(negedge clk); clrFlags = 1'b1;
    @(negedge clk); clrFlags = 1'b0;
    check({dataDone, listDone, dmaSummary, txDone, rxDone} == 0, "R9 flags cleared",
          {dataDone, listDone, dmaSummary, txDone, rxDone}, 0);

    // chain out of address order, last descriptor trimmed by count
    putDesc(32'h0C0, 32'h8000_0018, 16, 32'h200, 32'h040);
    putDesc(32'h040, 32'hC000_0012, 16, 32'h240, 32'h080);
    putDesc(32'h080, 32'h8000_0014, 16, 32'h280, 0);
    fillBuf(32'h200, 4, 32'hB100_0000);
    fillBuf(32'h240, 4, 32'hB200_0000);
    fillBuf(32'h280, 4, 32'hB300_0000);
    expectTx(32'h200, 4); expectTx(32'h240, 4); expectTx(32'h280, 2);
    txBefore = txSeen;
    runDma(1, 40, 32'h0C0);
    check(txSeen - txBefore == 10, "R1 chain word count", txSeen - txBefore, 10);
    check(txExp.size() == 0, "R3 min(size,remaining) on last", txExp.size(), 0);
    check(mem[32'h0C0>>2] == 32'h0000_0018, "R4 first status", mem[32'h0C0>>2], 32'h18);
    check(mem[32'h040>>2] == 32'h4000_0012, "R4 error and no-irq bits kept", mem[32'h040>>2], 32'h4000_0012);
    check(mem[32'h080>>2] == 32'h0000_0014, "R4 last status", mem[32'h080>>2], 32'h14);
    check(mem[(32'h040>>2)+3] == 32'h080, "R1 next word untouched", mem[(32'h040>>2)+3], 32'h080);
    check(txDone && !rxDone && bytesLeft == 0, "R7 chain tx flags", {txDone, rxDone}, 2'b10);
    clearFlags();

    // card to memory, size 0 means max, unaligned buffer, count ends before last bit
    putDesc(32'h300, 32'h8000_0018, 0, 32'h3C2, 32'h340);
    putDesc(32'h340, 32'h8000_0004, 16, 32'h380, 0);
    mem[32'h3D8>>2] = 32'hDEAD_BEEF;
    begin
      int rx0;
      rx0 = rxIdx;
      cardDataReady = 1'b1;
      runDma(0, 24, 32'h300);
      for (int k = 0; k < 6; k++)
        check(mem[(32'h3C0>>2)+k] == 32'hC0DE_0000 + rx0 + k, "R3 rx word at masked address",
              mem[(32'h3C0>>2)+k], 32'hC0DE_0000 + rx0 + k);
    end
    check(mem[32'h3D8>>2] == 32'hDEAD_BEEF, "R2 size zero bounded by count", mem[32'h3D8>>2], 32'hDEAD_BEEF);
    check(mem[32'h340>>2] == 32'h8000_0004, "R5 stop at zero count", mem[32'h340>>2], 32'h8000_0004);
    check(mem[32'h300>>2] == 32'h0000_0018, "R4 rx status written back", mem[32'h300>>2], 32'h18);
    check({dataDone, listDone, dmaSummary, txDone, rxDone} == 5'b11101, "R7 rx completion flags",
          {dataDone, listDone, dmaSummary, txDone, rxDone}, 5'b11101);
    clearFlags();

    // oversize clamp and size-zero max; stops on last bit with bytes still owed
    putDesc(32'h000, 32'h8000_0010, 100, 32'h100, 32'h020);
    putDesc(32'h020, 32'h8000_0004, 0, 32'h200, 0);
    fillBuf(32'h100, 16, 32'hD100_0000);
    fillBuf(32'h200, 16, 32'hD200_0000);
    expectTx(32'h100, 16); expectTx(32'h200, 16);
    txBefore = txSeen;
    runDma(1, 200, 32'h000);
    check(txSeen - txBefore == 32, "R2 clamp to max each", txSeen - txBefore, 32);
    check(bytesLeft == 72, "R8 remaining after last bit", bytesLeft, 72);
    check(listDone && dataDone && txDone, "R5 stop on last bit flags", {listDone, dataDone, txDone}, 3'b111);
    clearFlags();

    // refused starts
    mem[0] = 32'h8000_0004;
    seenBefore = memReqSeen;
    dmaEnable = 1'b0;
    runDma(1, 16, 32'h000);
    dmaEnable = 1'b1;
    blockSize = 0;
    runDma(1, 16, 32'h000);
    blockSize = 512;
    runDma(1, 0, 32'h000);
    cardDataReady = 1'b0;
    runDma(0, 16, 32'h000);
    cardDataReady = 1'b1;
    check(memReqSeen == seenBefore, "R6 no memory access", memReqSeen - seenBefore, 0);
    check(bytesLeft == 72, "R6 count not reloaded", bytesLeft, 72);
    check({dataDone, listDone, dmaSummary, txDone, rxDone} == 0, "R6 no flags",
          {dataDone, listDone, dmaSummary, txDone, rxDone}, 0);
    check(mem[0] == 32'h8000_0004, "R6 descriptor untouched", mem[0], 32'h8000_0004);
    check(!busy, "R10 idle after runs", busy, 0);
    finishRun();
  end
endmodule